// File: doc/BRIEF.md
# Way-Predicted Two-Way Read Cache

This block is a two-way set-associative read cache. It tries to answer in the time a direct-mapped cache needs while keeping the lower conflict-miss rate of two ways. Each set keeps one prediction bit that names the way expected to hit next. When a request arrives, that bit steers the output data multiplexer before any tag result exists. Only the predicted way's tag is compared, and the compare runs alongside the data array read.

If the predicted tag does not match, the other way is compared in the next cycle. On a hit there, the prediction bit moves to that way. If neither way holds the line, the cache asks next-level memory for the whole line and writes it into the least recently used way. It then answers with the requested word. Hit time is therefore one or two cycles, and the requester must accept a variable delay. It does this by watching `req_ready` and the one-cycle `rsp_valid` pulse.

Top module: `waypred_cache`

## Requirements
- R1: After reset all lines are invalid, every prediction bit and every LRU bit point at way 0, `req_ready` is 1, and `rsp_valid` and `mem_req` are 0. The first access to any set therefore misses.
- R2: Address fields, from the least significant end:
  - the low `OFF_W` bits select the word in a line;
  - the next `IDX_W` bits select the set;
  - the remaining bits are the tag.

  Every response carries the word that next-level memory holds at the requested address.
- R3: A hit in the predicted way gives `rsp_valid` in the first cycle after acceptance, with `rsp_late`=0 and `rsp_miss`=0. `req_ready` stays 1 in that cycle, so a new request can be accepted at the same edge.
- R4: A hit only in the non-predicted way gives `rsp_valid` in the second cycle after acceptance, with `rsp_late`=1. `req_ready` is 0 in both cycles.
- R5: After a second-cycle hit, the prediction bit of that set points at the way that hit. After a refill, it points at the filled way.
- R6: On a miss in both ways, `mem_req` is a one-cycle pulse in the third cycle after acceptance. In that cycle `mem_addr` carries the line address (the request address without its word-offset bits).
- R7: A refill takes line words in offset order 0 up to the last, one word per cycle in which `mem_valid` is 1. `rsp_valid` with `rsp_miss`=1 follows in the cycle after the last word. `req_ready` is 0 from acceptance up to and including that response cycle.
- R8: The refilled way is the least recently used way of the set. Every hit and every refill marks the way it used as most recent.
- R9: `mem_valid` pulses that arrive outside a refill's word-collection phase change no stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request accepted at this edge when high |
| req_addr | input | ADDR_W | Word address of the read |
| rsp_valid | output | 1 | One-cycle pulse: read data valid |
| rsp_data | output | DATA_W | Read data |
| rsp_late | output | 1 | Response came from the second-cycle compare |
| rsp_miss | output | 1 | Response came after a line refill |
| mem_req | output | 1 | One-cycle line fetch request |
| mem_addr | output | ADDR_W-OFF_W | Line address of the fetch |
| mem_valid | input | 1 | Refill word present |
| mem_data | input | DATA_W | Refill word |

## Verification
The bench drives one set through alternating tags so that the predictor is wrong on purpose. A design that forgets to move the prediction after a second-cycle hit would keep answering late, and a design that compares both tags at once would answer early. A third tag in a full set checks the LRU choice, because evicting the wrong way turns a later expected hit into a refill of a different length. Back-to-back predicted hits check that a single-cycle hit does not drop `req_ready`. Spurious `mem_valid` pulses while the cache is idle or hitting would corrupt data if the fill path were left open, and the reference model would catch that on the next read.

// File: rtl/waypred_cache.sv
`timescale 1ns/1ps
module waypred_cache #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int OFF_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_addr,
  output logic                    rsp_valid,
  output logic [DATA_W-1:0]       rsp_data,
  output logic                    rsp_late,
  output logic                    rsp_miss,
  output logic                    mem_req,
  output logic [ADDR_W-OFF_W-1:0] mem_addr,
  input  logic                    mem_valid,
  input  logic [DATA_W-1:0]       mem_data
);
  localparam int SETS  = 1 << IDX_W;
  localparam int WORDS = 1 << OFF_W;
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam int SLOTS = SETS * WORDS;

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_ALT, S_MREQ, S_FILL, S_DONE} state_t;

  state_t            state;
  logic [TAG_W-1:0]  a_tag;
  logic [IDX_W-1:0]  a_idx;
  logic [OFF_W-1:0]  a_off;
  logic [OFF_W-1:0]  beat;
  logic              vw;
  logic [SETS-1:0]   pred;
  logic [SETS-1:0]   lru;
  logic [SETS-1:0]   vld [2];
  logic [TAG_W-1:0]  tags [2][SETS];
  logic [DATA_W-1:0] lines [2][SLOTS];

  logic pw, ow, pw_hit, ow_hit, last_beat;

  assign pw        = pred[a_idx];
  assign ow        = ~pw;
  assign pw_hit    = vld[pw][a_idx] && (tags[pw][a_idx] == a_tag);
  assign ow_hit    = vld[ow][a_idx] && (tags[ow][a_idx] == a_tag);
  assign last_beat = mem_valid && (beat == OFF_W'(WORDS - 1));

  assign req_ready = (state == S_IDLE) || (state == S_LOOK && pw_hit);
  assign rsp_valid = (state == S_LOOK && pw_hit) || (state == S_ALT && ow_hit) || (state == S_DONE);
  assign rsp_late  = (state == S_ALT && ow_hit);
  assign rsp_miss  = (state == S_DONE);
  assign mem_req   = (state == S_MREQ);
  assign mem_addr  = {a_tag, a_idx};

  always_comb begin
    case (state)
      S_LOOK:  rsp_data = lines[pw][{a_idx, a_off}];
      S_ALT:   rsp_data = lines[ow][{a_idx, a_off}];
      default: rsp_data = lines[vw][{a_idx, a_off}];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      pred   <= '0;
      lru    <= '0;
      vld[0] <= '0;
      vld[1] <= '0;
      a_tag  <= '0;
      a_idx  <= '0;
      a_off  <= '0;
      beat   <= '0;
      vw     <= 1'b0;
    end else begin
      case (state)
        S_IDLE, S_LOOK: begin
          if (state == S_LOOK && !pw_hit) begin
            state <= S_ALT;
          end else begin
            if (state == S_LOOK) lru[a_idx] <= ow;
            if (req_valid) begin
              {a_tag, a_idx, a_off} <= req_addr;
              state <= S_LOOK;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        S_ALT: begin
          if (ow_hit) begin
            pred[a_idx] <= ow;
            lru[a_idx]  <= pw;
            state       <= S_IDLE;
          end else begin
            vw                   <= lru[a_idx];
            vld[lru[a_idx]][a_idx] <= 1'b0;
            beat                 <= '0;
            state                <= S_MREQ;
          end
        end
        S_MREQ: state <= S_FILL;
        S_FILL: begin
          if (mem_valid) begin
            beat <= beat + 1'b1;
            if (last_beat) begin
              vld[vw][a_idx] <= 1'b1;
              pred[a_idx]    <= vw;
              lru[a_idx]     <= ~vw;
              state          <= S_DONE;
            end
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_FILL && mem_valid) begin
      lines[vw][{a_idx, beat}] <= mem_data;
      if (last_beat) tags[vw][a_idx] <= a_tag;
    end
  end
endmodule

// File: rtl/waypred_cache_chk.sv
`timescale 1ns/1ps
module waypred_cache_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_valid,
  input logic rsp_late,
  input logic rsp_miss,
  input logic mem_req
);
  // R3
  first_cycle_not_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!rsp_late && !rsp_miss));

  // R3
  fast_hit_keeps_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_late && !rsp_miss) |-> req_ready);

  // R4
  late_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_late |-> (rsp_valid && !req_ready && !rsp_miss && $past(!req_ready) && $past(!rsp_valid)));

  // R6
  fetch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R6
  fetch_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (!req_ready && !rsp_valid));

  // R7
  miss_rsp_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (rsp_valid && !req_ready && $past(!req_ready)));
endmodule

bind waypred_cache waypred_cache_chk u_waypred_cache_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_late  (rsp_late),
  .rsp_miss  (rsp_miss),
  .mem_req   (mem_req)
);

// File: tb/test_waypred_cache.sv
`timescale 1ns/1ps
module test_waypred_cache;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 32;
  localparam int IDX_W    = 4;
  localparam int OFF_W    = 2;
  localparam int SETS     = 1 << IDX_W;
  localparam int WORDS    = 1 << OFF_W;
  localparam int MEM_LAT  = 2;
  localparam int MISS_LAT = 3 + MEM_LAT + WORDS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic                    req_valid, req_ready, rsp_valid, rsp_late, rsp_miss, mem_req, mem_valid;
  logic [ADDR_W-1:0]       req_addr;
  logic [DATA_W-1:0]       rsp_data, mem_data;
  logic [ADDR_W-OFF_W-1:0] mem_addr;

  waypred_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) i_waypred_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_late(rsp_late), .rsp_miss(rsp_miss),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_data(mem_data));

  int compared = 0;
  int mismatched = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
    return {a ^ 16'h5A3C, a};
  endfunction

  function automatic int mk(input int tg, input int st, input int of);
    return (tg << (IDX_W + OFF_W)) | (st << OFF_W) | of;
  endfunction

  // reference model state
  int  m_tag [2][SETS];
  bit  m_vld [2][SETS];
  bit  m_pred [SETS];
  bit  m_lru [SETS];
  int  pend [$];
  bit  busy = 0, acc = 0, junk_en = 0, mact = 0;
  int  cnt = 0, lat = 0, kind = 0, mt = 0, cyc = 0;
  logic [ADDR_W-1:0] cur_addr, acc_addr;
  logic [ADDR_W-OFF_W-1:0] mline;

  task automatic classify(input logic [ADDR_W-1:0] a);
    int s, t, p, o, v;
    s = (a >> OFF_W) & (SETS - 1);
    t = a >> (OFF_W + IDX_W);
    p = m_pred[s];
    o = 1 - p;
    cur_addr = a;
    if (m_vld[p][s] && m_tag[p][s] == t) begin
      lat = 1; kind = 0; m_lru[s] = bit'(o);
    end else if (m_vld[o][s] && m_tag[o][s] == t) begin
      lat = 2; kind = 1; m_pred[s] = bit'(o); m_lru[s] = bit'(p);
    end else begin
      lat = MISS_LAT; kind = 2; v = m_lru[s];
      m_tag[v][s] = t; m_vld[v][s] = 1'b1; m_pred[s] = bit'(v); m_lru[s] = bit'(1 - v);
    end
  endtask

  task automatic step();
    bit exp_rv, exp_rdy, exp_mreq;
    string ktag;
    cyc++;
    if (acc) begin classify(acc_addr); busy = 1; cnt = 0; end
    acc = 0;
    if (busy) cnt++;
    exp_rv   = busy && cnt == lat;
    exp_rdy  = !busy || (kind == 0 && cnt == 1);
    exp_mreq = busy && kind == 2 && cnt == 3;
    ktag = !busy ? "R1 R3" : (kind == 0 ? "R3" : (kind == 1 ? "R4 R5" : "R7 R8"));
    chk({ktag, " ready"}, req_ready, exp_rdy);
    chk({ktag, " rsp_valid"}, rsp_valid, exp_rv);
    chk("R4 rsp_late", rsp_late, exp_rv && kind == 1);
    chk("R7 rsp_miss", rsp_miss, exp_rv && kind == 2);
    chk("R6 mem_req", mem_req, exp_mreq);
    if (exp_mreq) chk("R6 mem_addr", mem_addr, cur_addr >> OFF_W);
    if (exp_rv) chk(junk_en ? "R9 R2 data" : "R2 data", rsp_data, mem_word(cur_addr));
    if (exp_rv) busy = 0;

    if (mact) begin
      mt++;
      if (mt >= MEM_LAT && mt < MEM_LAT + WORDS) begin
        mem_valid = 1'b1;
        mem_data  = mem_word(ADDR_W'((int'(mline) << OFF_W) | (mt - MEM_LAT)));
      end else begin
        mem_valid = 1'b0;
        if (mt >= MEM_LAT + WORDS) mact = 0;
      end
    end else if (mem_req === 1'b1) begin
      mact = 1; mt = 0; mline = mem_addr; mem_valid = 1'b0;
    end else if (junk_en && !(busy && kind == 2) && (cyc % 3 == 0)) begin
      mem_valid = 1'b1;
      mem_data  = 32'hDEAD_0BAD ^ cyc;
    end else begin
      mem_valid = 1'b0;
    end

    if (pend.size() > 0) begin
      if (pend[0] < 0) begin
        req_valid = 1'b0;
        req_addr  = 16'hFFFF;
        void'(pend.pop_front());
      end else begin
        req_valid = 1'b1;
        req_addr  = ADDR_W'(pend[0]);
        if (req_ready) begin
          acc = 1;
          acc_addr = ADDR_W'(pend[0]);
          void'(pend.pop_front());
        end
      end
    end else begin
      req_valid = 1'b0;
    end
  endtask

  initial begin
    req_valid = 1'b0; req_addr = '0; mem_valid = 1'b0; mem_data = '0;
    forever begin
      @(negedge clk);
      if (rst_n) step();
    end
  end

  task automatic drain();
    @(posedge clk);
    while (pend.size() != 0 || busy || acc || mact) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    int unsigned seed;
    repeat (3) @(negedge clk);
    // R1 reset outputs
    chk("R1 ready", req_ready, 1'b1);
    chk("R1 rsp_valid", rsp_valid, 1'b0);
    chk("R1 mem_req", mem_req, 1'b0);
    @(posedge clk);
    rst_n <= 1'b1;

    // set 0: miss, same-line hit, second tag, mispredicted hits, eviction by LRU
    pend.push_back(mk(1, 0, 0));
    pend.push_back(mk(1, 0, 3));
    pend.push_back(mk(2, 0, 1));
    pend.push_back(mk(1, 0, 2));
    pend.push_back(mk(1, 0, 0));
    pend.push_back(mk(2, 0, 1));
    pend.push_back(mk(3, 0, 0));
    pend.push_back(mk(1, 0, 0));
    pend.push_back(mk(3, 0, 1));
    pend.push_back(mk(3, 0, 2));
    pend.push_back(mk(3, 0, 3));
    pend.push_back(-1);
    pend.push_back(mk(1, 5, 1));
    pend.push_back(mk(1, 5, 2));
    pend.push_back(mk(1, 0, 3));
    drain();

    junk_en = 1;
    seed = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      if (((seed >> 20) % 6) == 0) pend.push_back(-1);
      else pend.push_back(mk(int'((seed >> 8) & 3), int'((seed >> 12) & 3), int'((seed >> 16) & 3)));
    end
    drain();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule